// File: doc/BRIEF.md
# GPIO Signal Routing Crossbar

This block sits between a bank of GPIO pads and the chip's internal peripherals. It decides, under software control, which internal signal drives each pad, which internal signal gates each pad's output enable, and which pad feeds each internal input. Each routing choice is one byte-wide selection code held in a register. Four codes are packed into every 32-bit word. Codes 0 and 1 always stand for a constant low and a constant high source. Larger codes name a real source, offset by two.

Output routing and enable routing are indexed by pad. Input routing is indexed by the internal destination signal, and its code is the pad number plus two. A read-only bank returns the present level of every pad, one bit per pad. A plain 32-bit port gives access to every field. A write lands in one cycle, and read data appears one cycle after the address. Software changes a single field by reading the word, replacing one byte and writing the word back. The routing paths from sources to pads and from pads to internal inputs are purely combinational.

Top module: `pad_route_xbar`

## Requirements
- R1: After reset every selection field is 0, so every `pad_oe` and `pad_out` bit is 0, every `core_din` bit is 0 whatever the pads carry, and `cfg_rdata` is 0.
- R2: The output-select code for pad p sits at byte address OUT_BASE + 4*(p/4), bits 8*(p%4)+7 down to 8*(p%4). Code 0 drives `pad_out[p]` low and code 1 drives it high. A code k from 2 to NUM_SRC_OUT+1 drives it from `core_dout[k-2]`, and any larger code drives it low.
- R3: The enable-select code for pad p uses the same packing at OE_BASE. Code 1 is the unconditional enable, so `pad_oe[p]`=1. Code 0 gives `pad_oe[p]`=0. A code k from 2 to NUM_SRC_OE+1 takes `core_doen[k-2]`, and any larger code gives 0.
- R4: The input-select code for destination s sits at IN_BASE + 4*(s/4), bits 8*(s%4)+7 down to 8*(s%4). Code 0 gives `core_din[s]`=0 and code 1 gives 1. A code P+2 with P < NUM_PADS gives `pad_in[P]`, and any larger code gives 0.
- R5: Reading a field word returns the written bytes unchanged. A byte lane that has no pad or destination behind it reads 0, and writes to that lane are dropped.
- R6: The word at LVL_BASE + 4*(n/32) returns `pad_in[n]` in bit n%32 as sampled at the read's address edge. Bits with no pad read 0. Writes to this bank change no field.
- R7: A write changes the routed outputs right after the clock edge that samples `cfg_wen`, and not before. Read data appears at the edge that samples `cfg_ren`. `cfg_rdata` holds its value while `cfg_ren` is low.
- R8: A write to one word leaves every field of every other word unchanged.
- R9: Writes to addresses outside all four banks change nothing, and reads from them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wen | input | 1 | Write strobe, one word per cycle |
| cfg_ren | input | 1 | Read strobe |
| cfg_addr | input | ADDR_W | Byte address, word aligned |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, registered |
| core_dout | input | NUM_SRC_OUT | Internal output sources |
| core_doen | input | NUM_SRC_OE | Internal output-enable sources, high means drive |
| core_din | output | NUM_DST_IN | Internal input destinations |
| pad_in | input | NUM_PADS | Level seen at each pad |
| pad_out | output | NUM_PADS | Value driven toward each pad |
| pad_oe | output | NUM_PADS | Drive enable for each pad |

## Verification
The bench aims at the offset-by-two coding. It uses codes just past the last source or pad, which must give 0. A design that forgot the offset, or that indexed past the source vector, would route a neighbouring signal or leave a stray 1 on the pad. It writes the partly filled last words of the output and input banks and reads them back. A design that stored the spare lanes would return the written bytes instead of zeros. It also writes the read-only level bank and unmapped addresses, then checks that no routing changed, and it confirms that a write shows on the pads only after its clock edge, which catches an off-by-one-cycle address decode.

// File: rtl/pad_route_pkg.sv
package pad_route_pkg;
   localparam int FIELD_W     = 8;
   localparam int LANES       = 32 / FIELD_W;
   localparam int LVL_PER_WORD = 32;
   localparam int CODE_LOW    = 0;
   localparam int CODE_HIGH   = 1;
   localparam int CODE_FIRST  = 2;

   typedef logic [FIELD_W-1:0] sel_code_t;

   function automatic int words_for(input int n, input int per_word);
      return (n + per_word - 1) / per_word;
   endfunction
endpackage

// File: rtl/pad_route_sel.sv
module pad_route_sel
   import pad_route_pkg::*;
#(
   parameter int N_IN = 4
) (
   input  sel_code_t        code,
   input  logic [N_IN-1:0]  src,
   output logic             y
);
   localparam int IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1;

   if (N_IN < 3) begin : g_bad_width
      $error("pad_route_sel: N_IN must cover both constants and one source");
   end
   if (IDX_W > FIELD_W) begin : g_bad_code
      $error("pad_route_sel: N_IN exceeds what one code byte can name");
   end

   logic [IDX_W-1:0] idx;
   logic             in_range;

   assign idx      = code[IDX_W-1:0];
   assign in_range = (32'(code) < N_IN);
   assign y        = in_range ? src[idx] : 1'b0;
endmodule

// File: rtl/pad_route_regs.sv
module pad_route_regs
   import pad_route_pkg::*;
#(
   parameter int NUM_PADS   = 18,
   parameter int NUM_DST_IN = 9,
   parameter int ADDR_W     = 8,
   parameter int OUT_BASE   = 'h00,
   parameter int OE_BASE    = 'h20,
   parameter int IN_BASE    = 'h40,
   parameter int LVL_BASE   = 'h60
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               cfg_wen,
   input  logic                               cfg_ren,
   input  logic [ADDR_W-1:0]                  cfg_addr,
   input  logic [31:0]                        cfg_wdata,
   output logic [31:0]                        cfg_rdata,
   input  logic [NUM_PADS-1:0]                pad_in,
   output logic [NUM_PADS-1:0][FIELD_W-1:0]   out_sel,
   output logic [NUM_PADS-1:0][FIELD_W-1:0]   oe_sel,
   output logic [NUM_DST_IN-1:0][FIELD_W-1:0] in_sel
);
   localparam int PAD_WORDS = words_for(NUM_PADS, LANES);
   localparam int IN_WORDS  = words_for(NUM_DST_IN, LANES);
   localparam int LVL_WORDS = words_for(NUM_PADS, LVL_PER_WORD);
   localparam int OUT_W0    = OUT_BASE / 4;
   localparam int OE_W0     = OE_BASE / 4;
   localparam int IN_W0     = IN_BASE / 4;
   localparam int LVL_W0    = LVL_BASE / 4;

   int unsigned widx;
   logic        hit;
   logic [31:0] rword;

   assign widx = 32'(cfg_addr) >> 2;

   // bank decode, kept apart from the data mux so the two can be cross-checked
   always_comb begin
      hit = 1'b0;
      if (widx >= OUT_W0 && widx < OUT_W0 + PAD_WORDS) hit = 1'b1;
      if (widx >= OE_W0  && widx < OE_W0  + PAD_WORDS) hit = 1'b1;
      if (widx >= IN_W0  && widx < IN_W0  + IN_WORDS)  hit = 1'b1;
      if (widx >= LVL_W0 && widx < LVL_W0 + LVL_WORDS) hit = 1'b1;
   end

   for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
      localparam int unsigned WO = OUT_W0 + p / LANES;
      localparam int unsigned WE = OE_W0 + p / LANES;
      localparam int          L  = p % LANES;
      sel_code_t out_q, oe_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_q <= '0;
            oe_q  <= '0;
         end else begin
            if (cfg_wen && widx == WO) out_q <= cfg_wdata[FIELD_W*L +: FIELD_W];
            if (cfg_wen && widx == WE) oe_q  <= cfg_wdata[FIELD_W*L +: FIELD_W];
         end
      end
      assign out_sel[p] = out_q;
      assign oe_sel[p]  = oe_q;

      // R7: an output-select write is visible in the field after one edge
      p_out_write_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_wen && widx == WO) |=> out_sel[p] == $past(cfg_wdata[FIELD_W*L +: FIELD_W]));
      // R8: a field keeps its value when its own word is not written
      p_out_isolated_r8: assert property (@(posedge clk) disable iff (!rst_n)
         !(cfg_wen && widx == WO) |=> $stable(out_sel[p]));
      p_oe_isolated_r8: assert property (@(posedge clk) disable iff (!rst_n)
         !(cfg_wen && widx == WE) |=> $stable(oe_sel[p]));
   end

   for (genvar s = 0; s < NUM_DST_IN; s++) begin : g_dst
      localparam int unsigned WI = IN_W0 + s / LANES;
      localparam int          L  = s % LANES;
      sel_code_t in_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                     in_q <= '0;
         else if (cfg_wen && widx == WI) in_q <= cfg_wdata[FIELD_W*L +: FIELD_W];
      end
      assign in_sel[s] = in_q;

      p_in_isolated_r8: assert property (@(posedge clk) disable iff (!rst_n)
         !(cfg_wen && widx == WI) |=> $stable(in_sel[s]));
   end

   always_comb begin
      rword = '0;
      for (int p = 0; p < NUM_PADS; p++) begin
         if (widx == 32'(OUT_W0 + p / LANES)) rword[FIELD_W*(p % LANES) +: FIELD_W] = out_sel[p];
         if (widx == 32'(OE_W0 + p / LANES))  rword[FIELD_W*(p % LANES) +: FIELD_W] = oe_sel[p];
         if (widx == 32'(LVL_W0 + p / LVL_PER_WORD)) rword[p % LVL_PER_WORD] = pad_in[p];
      end
      for (int s = 0; s < NUM_DST_IN; s++) begin
         if (widx == 32'(IN_W0 + s / LANES)) rword[FIELD_W*(s % LANES) +: FIELD_W] = in_sel[s];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cfg_rdata <= '0;
      else if (cfg_ren) cfg_rdata <= rword;
   end

   // R7: read data only moves on a read strobe
   p_rdata_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_ren |=> $stable(cfg_rdata));
   // R9: reads outside every bank return zero
   p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_ren && !hit) |=> cfg_rdata == 32'h0);
endmodule

// File: rtl/pad_route_xbar.sv
module pad_route_xbar
   import pad_route_pkg::*;
#(
   parameter int NUM_PADS    = 18,
   parameter int NUM_SRC_OUT = 40,
   parameter int NUM_SRC_OE  = 10,
   parameter int NUM_DST_IN  = 9,
   parameter int ADDR_W      = 8,
   parameter int OUT_BASE    = 'h00,
   parameter int OE_BASE     = 'h20,
   parameter int IN_BASE     = 'h40,
   parameter int LVL_BASE    = 'h60
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_wen,
   input  logic                  cfg_ren,
   input  logic [ADDR_W-1:0]     cfg_addr,
   input  logic [31:0]           cfg_wdata,
   output logic [31:0]           cfg_rdata,
   input  logic [NUM_SRC_OUT-1:0] core_dout,
   input  logic [NUM_SRC_OE-1:0] core_doen,
   output logic [NUM_DST_IN-1:0] core_din,
   input  logic [NUM_PADS-1:0]   pad_in,
   output logic [NUM_PADS-1:0]   pad_out,
   output logic [NUM_PADS-1:0]   pad_oe
);
   localparam int PAD_WORDS = words_for(NUM_PADS, LANES);
   localparam int IN_WORDS  = words_for(NUM_DST_IN, LANES);
   localparam int LVL_WORDS = words_for(NUM_PADS, LVL_PER_WORD);
   localparam int OUT_SPAN  = NUM_SRC_OUT + CODE_FIRST;
   localparam int OE_SPAN   = NUM_SRC_OE + CODE_FIRST;
   localparam int IN_SPAN   = NUM_PADS + CODE_FIRST;

   // elaboration checks on the parameter set
   if (OUT_BASE % 4 != 0 || OE_BASE % 4 != 0 || IN_BASE % 4 != 0 || LVL_BASE % 4 != 0) begin : g_chk_align
      $error("pad_route_xbar: bank bases must be word aligned");
   end
   if (OUT_BASE + 4*PAD_WORDS > OE_BASE || OE_BASE + 4*PAD_WORDS > IN_BASE ||
       IN_BASE + 4*IN_WORDS > LVL_BASE) begin : g_chk_overlap
      $error("pad_route_xbar: banks overlap or are out of order");
   end
   if (LVL_BASE + 4*LVL_WORDS > (1 << ADDR_W)) begin : g_chk_space
      $error("pad_route_xbar: banks exceed the address space");
   end
   if (OUT_SPAN > 256 || OE_SPAN > 256 || IN_SPAN > 256) begin : g_chk_codes
      $error("pad_route_xbar: sources exceed one code byte");
   end

   logic [NUM_PADS-1:0][FIELD_W-1:0]   out_sel;
   logic [NUM_PADS-1:0][FIELD_W-1:0]   oe_sel;
   logic [NUM_DST_IN-1:0][FIELD_W-1:0] in_sel;

   // constant sources occupy codes 0 and 1 of every source vector
   logic [OUT_SPAN-1:0] out_src;
   logic [OE_SPAN-1:0]  oe_src;
   logic [IN_SPAN-1:0]  in_src;

   assign out_src = {core_dout, 1'b1, 1'b0};
   assign oe_src  = {core_doen, 1'b1, 1'b0};
   assign in_src  = {pad_in,    1'b1, 1'b0};

   pad_route_regs #(
      .NUM_PADS   (NUM_PADS),
      .NUM_DST_IN (NUM_DST_IN),
      .ADDR_W     (ADDR_W),
      .OUT_BASE   (OUT_BASE),
      .OE_BASE    (OE_BASE),
      .IN_BASE    (IN_BASE),
      .LVL_BASE   (LVL_BASE)
   ) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_wen   (cfg_wen),
      .cfg_ren   (cfg_ren),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .pad_in    (pad_in),
      .out_sel   (out_sel),
      .oe_sel    (oe_sel),
      .in_sel    (in_sel)
   );

   for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
      pad_route_sel #(.N_IN(OUT_SPAN)) dout_mux_i (
         .code (out_sel[p]), .src (out_src), .y (pad_out[p]));
      pad_route_sel #(.N_IN(OE_SPAN)) doen_mux_i (
         .code (oe_sel[p]), .src (oe_src), .y (pad_oe[p]));

      // R2: constant codes reach the pad
      p_out_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (out_sel[p] == FIELD_W'(CODE_LOW)) |-> !pad_out[p]);
      p_out_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (out_sel[p] == FIELD_W'(CODE_HIGH)) |-> pad_out[p]);
      p_out_overrange_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (32'(out_sel[p]) >= OUT_SPAN) |-> !pad_out[p]);
      // R3: only the enable code or a routed enable turns the driver on
      p_oe_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (oe_sel[p] == FIELD_W'(CODE_HIGH)) |-> pad_oe[p]);
      p_oe_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (oe_sel[p] == FIELD_W'(CODE_LOW) || 32'(oe_sel[p]) >= OE_SPAN) |-> !pad_oe[p]);
   end

   for (genvar s = 0; s < NUM_DST_IN; s++) begin : g_dst
      pad_route_sel #(.N_IN(IN_SPAN)) din_mux_i (
         .code (in_sel[s]), .src (in_src), .y (core_din[s]));

      // R4: constant and out-of-range input codes
      p_in_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (in_sel[s] == FIELD_W'(CODE_LOW) || 32'(in_sel[s]) >= IN_SPAN) |-> !core_din[s]);
      p_in_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (in_sel[s] == FIELD_W'(CODE_HIGH)) |-> core_din[s]);
   end
endmodule

// File: tb/pad_route_xbar_tb_top.sv
module pad_route_xbar_tb_top;
   localparam int NP  = 18;
   localparam int NSO = 40;
   localparam int NSE = 10;
   localparam int NDI = 9;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           cfg_wen = 1'b0;
   logic           cfg_ren = 1'b0;
   logic [7:0]     cfg_addr = '0;
   logic [31:0]    cfg_wdata = '0;
   logic [31:0]    cfg_rdata;
   logic [NSO-1:0] core_dout = '0;
   logic [NSE-1:0] core_doen = '0;
   logic [NDI-1:0] core_din;
   logic [NP-1:0]  pad_in = '1;
   logic [NP-1:0]  pad_out;
   logic [NP-1:0]  pad_oe;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   pad_route_xbar dut_i (
      .clk (clk), .rst_n (rst_n), .cfg_wen (cfg_wen), .cfg_ren (cfg_ren),
      .cfg_addr (cfg_addr), .cfg_wdata (cfg_wdata), .cfg_rdata (cfg_rdata),
      .core_dout (core_dout), .core_doen (core_doen), .core_din (core_din),
      .pad_in (pad_in), .pad_out (pad_out), .pad_oe (pad_oe)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fails++;
         $display("FAIL %s got %h exp %h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_wen = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_wen = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      cfg_ren = 1'b1; cfg_addr = a;
      @(negedge clk);
      cfg_ren = 1'b0;
      d = cfg_rdata;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      chk("R1 rdata after reset", cfg_rdata, 32'h0);
      chk("R1 pad_oe", 32'(pad_oe), 32'h0);
      chk("R1 pad_out", 32'(pad_out), 32'h0);
      chk("R1 core_din with pads high", 32'(core_din), 32'h0);
      rd(8'h00, d); chk("R1 out word0", d, 32'h0);
      rd(8'h40, d); chk("R1 in word0", d, 32'h0);
   endtask

   task automatic t_out_route();
      wr(8'h00, 32'h0100_0729);
      core_dout = '0; core_dout[39] = 1'b1;
      @(negedge clk); chk("R2 pads 3..0 src39", 32'(pad_out[3:0]), 32'h9);
      core_dout = '0; core_dout[5] = 1'b1;
      @(negedge clk); chk("R2 pads 3..0 src5", 32'(pad_out[3:0]), 32'hA);
      core_dout = '1;
      wr(8'h04, 32'h0000_002A);
      chk("R2 code past last source", 32'(pad_out[4]), 32'h0);
      wr(8'h10, 32'h0000_0100);
      chk("R2 pads 17..16 consts", 32'(pad_out[17:16]), 32'h2);
   endtask

   task automatic t_oe_route();
      wr(8'h20, 32'h0C00_0501);
      core_doen = 10'h008;
      @(negedge clk); chk("R3 oe routed high", 32'(pad_oe[3:0]), 32'h3);
      core_doen = 10'h3F7;
      @(negedge clk); chk("R3 oe routed low", 32'(pad_oe[3:0]), 32'h1);
   endtask

   task automatic t_in_route();
      wr(8'h40, 32'h1413_0100);
      wr(8'h48, 32'h0000_0002);
      pad_in = 18'h3FFFF;
      @(negedge clk);
      chk("R4 din 3..0 pads high", 32'(core_din[3:0]), 32'h6);
      chk("R4 din8 from pad0 high", 32'(core_din[8]), 32'h1);
      chk("R4 unprogrammed dests low", 32'(core_din[7:4]), 32'h0);
      pad_in = 18'h1FFFE;
      @(negedge clk);
      chk("R4 din 3..0 pad17 low", 32'(core_din[3:0]), 32'h2);
      chk("R4 din8 from pad0 low", 32'(core_din[8]), 32'h0);
   endtask

   task automatic t_readback();
      logic [31:0] d;
      rd(8'h20, d); chk("R5 oe word0 readback", d, 32'h0C00_0501);
      wr(8'h10, 32'hAABB_0103);
      rd(8'h10, d); chk("R5 spare lanes of out word4", d, 32'h0000_0103);
      wr(8'h48, 32'hDDCC_BB02);
      rd(8'h48, d); chk("R5 spare lanes of in word2", d, 32'h0000_0002);
   endtask

   task automatic t_level();
      logic [31:0] d;
      pad_in = 18'h25A5C;
      rd(8'h60, d); chk("R6 level word", d, 32'h0002_5A5C);
      wr(8'h60, 32'hFFFF_FFFF);
      rd(8'h00, d); chk("R6 level write leaves out word0", d, 32'h0100_0729);
      rd(8'h60, d); chk("R6 level still follows pads", d, 32'h0002_5A5C);
   endtask

   task automatic t_isolation();
      logic [31:0] d;
      core_dout = '0;
      wr(8'h04, 32'h0101_0101);
      chk("R8 pads 7..4 high", 32'(pad_out[7:4]), 32'hF);
      rd(8'h00, d); chk("R8 out word0 untouched", d, 32'h0100_0729);
      rd(8'h24, d); chk("R8 oe word1 untouched", d, 32'h0);
   endtask

   task automatic t_unmapped();
      logic [31:0] d;
      wr(8'h14, 32'hFFFF_FFFF);
      wr(8'h80, 32'hFFFF_FFFF);
      wr(8'h4C, 32'hFFFF_FFFF);
      rd(8'h14, d); chk("R9 read 0x14", d, 32'h0);
      rd(8'h80, d); chk("R9 read 0x80", d, 32'h0);
      rd(8'h4C, d); chk("R9 read 0x4C", d, 32'h0);
      rd(8'h04, d); chk("R9 out word1 unchanged", d, 32'h0101_0101);
      chk("R9 upper oe still off", 32'(pad_oe[17:4]), 32'h0);
   endtask

   task automatic t_timing();
      logic [31:0] d;
      core_dout = '0;
      wr(8'h00, 32'h0100_0700);
      chk("R7 pad0 low before", 32'(pad_out[0]), 32'h0);
      @(negedge clk);
      cfg_wen = 1'b1; cfg_addr = 8'h00; cfg_wdata = 32'h0100_0701;
      #2 chk("R7 no change before edge", 32'(pad_out[0]), 32'h0);
      @(negedge clk);
      cfg_wen = 1'b0;
      chk("R7 change after edge", 32'(pad_out[0]), 32'h1);
      rd(8'h00, d);
      chk("R7 read data", d, 32'h0100_0701);
      cfg_addr = 8'h60;
      @(negedge clk); @(negedge clk);
      chk("R7 rdata holds without strobe", cfg_rdata, 32'h0100_0701);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   endtask

   initial begin
      #(20 * 100000);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_out_route();
      t_oe_route();
      t_in_route();
      t_readback();
      t_level();
      t_isolation();
      t_unmapped();
      t_timing();
      finish_run();
   end
endmodule